// File: doc/BRIEF.md
# Parked-Read Memory Agent

This block sits on the memory side of a small shared-memory multiprocessor. Processors send it three kinds of request over one channel. An early read names a block and the processor that wants it. An ownership acquire tells the agent that some processor now holds the block exclusively, so the memory copy is stale. A writeback carries the producer's new data for the block. When an early read finds the memory copy valid, the agent answers at once. When it finds the copy stale, the agent does not refuse or retry the read. It records the block and the requester in a small table of waiting consumers. The next writeback to that block then pushes the fresh data to every consumer recorded against it.

Each block has one validity bit and one data word. The table holds a fixed number of (block, processor) entries and frees an entry once its response has been issued. Responses leave through a registered valid/ready channel, at most one per cycle. Deliveries caused by a writeback go out in ascending table-slot order. While they drain, the request channel is closed.

Top module: `consumer_park_agent`

## Requirements
- R1: After reset every block is valid and holds data 0, the table is empty, `rsp_valid` is 0 and `req_ready` is 1 for any request.
- R2: An accepted read (type 0) of a valid block produces a response in the next cycle. The response carries the requester ID, the block address and the block's current data.
- R3: An accepted ownership acquire (type 1) clears the block's validity bit. A later read of that block produces no response and is parked in the table.
- R4: An accepted writeback (type 2) stores its data in the block and sets the block valid. Later reads return the new data.
- R5: A writeback to a block with parked readers delivers the new data to each of them, starting the cycle after the writeback is accepted, one per free response slot. Deliveries go out in ascending slot order, and a new entry always takes the lowest free slot.
- R6: A read with the same block and ID as an entry already parked creates no second entry. That consumer gets exactly one delivery.
- R7: When all table slots are taken, a read of an invalid block that matches no parked entry sees `req_ready` low. A duplicate read is still accepted.
- R8: While writeback deliveries are draining, `req_ready` is low for every request type.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged, and a read of a valid block sees `req_ready` low.
- R10: A writeback delivers only to entries parked for its own block. Entries for other blocks remain parked and are delivered by their own writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Agent accepts the request this cycle |
| req_type | input | 2 | 0 read, 1 ownership acquire, 2 writeback, 3 reserved (accepted, no effect) |
| req_addr | input | ADDR_W | Block address |
| req_id | input | ID_W | Requesting processor |
| req_data | input | DATA_W | Writeback data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Receiver takes the response |
| rsp_id | output | ID_W | Destination processor |
| rsp_addr | output | ADDR_W | Block address of the data |
| rsp_data | output | DATA_W | Block data |

## Verification
A corrupted validity bit shows up on the cycle after the next read of that block. A response appears where none was due, or none appears where one was due. A lost or doubled table entry shows up only when the matching writeback drains: the delivery count is wrong, or the slot order is wrong. A stuck drain flag shows up as `req_ready` staying low one cycle after the last delivery. The bench therefore compares `req_ready` and every response field with a reference on every cycle. It also checks the delivery sequences, so table errors show up within a few cycles of the writeback.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_OWN  = 2'd1,
        OP_WB   = 2'd2,
        OP_RSVD = 2'd3
    } op_e;
endpackage

// File: rtl/cpa_first_set.sv
module cpa_first_set #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpa_pend_lookup.sv
module cpa_pend_lookup #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4,
    parameter int ID_W   = 3,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][ID_W-1:0]   ent_id,
    input  logic [ADDR_W-1:0]            q_addr,
    input  logic [ID_W-1:0]              q_id,
    input  logic [ADDR_W-1:0]            d_addr,
    output logic                         dup,
    output logic                         full,
    output logic [IDX_W-1:0]             alloc_idx,
    output logic [DEPTH-1:0]             addr_hits,
    output logic [DEPTH-1:0]             drain_hits
);
    logic [DEPTH-1:0] dup_vec;
    logic             free_found;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign addr_hits[g]  = ent_vld[g] && (ent_addr[g] == q_addr);
        assign dup_vec[g]    = addr_hits[g] && (ent_id[g] == q_id);
        assign drain_hits[g] = ent_vld[g] && (ent_addr[g] == d_addr);
    end

    assign dup = |dup_vec;

    cpa_first_set #(.W(DEPTH)) u_free (
        .vec   (~ent_vld),
        .idx   (alloc_idx),
        .found (free_found)
    );

    assign full = !free_found;
endmodule

// File: rtl/consumer_park_agent.sv
module consumer_park_agent #(
    parameter int ADDR_W = 4,
    parameter int ID_W   = 3,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ID_W-1:0]   rsp_id,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data
);
    import cpa_pkg::*;

    localparam int NBLK  = 1 << ADDR_W;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [NBLK-1:0]              bvld;
        logic [NBLK-1:0][DATA_W-1:0]  mem;
        logic [DEPTH-1:0]             tv;
        logic [DEPTH-1:0][ADDR_W-1:0] ta;
        logic [DEPTH-1:0][ID_W-1:0]   ti;
        logic                         rv;
        logic [ID_W-1:0]              rid;
        logic [ADDR_W-1:0]            ra;
        logic [DATA_W-1:0]            rd;
        logic                         drain;
        logic [ADDR_W-1:0]            da;
    } st_t;

    st_t st_q, st_d;

    logic              dup, full;
    logic [IDX_W-1:0]  alloc_idx;
    logic [DEPTH-1:0]  addr_hits, drain_hits, rest_hits;
    logic [IDX_W-1:0]  didx;
    logic              dfound;
    logic              slot_free, hit, op_ok, fire;
    op_e               op;

    cpa_pend_lookup #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W)
    ) u_lookup (
        .ent_vld    (st_q.tv),
        .ent_addr   (st_q.ta),
        .ent_id     (st_q.ti),
        .q_addr     (req_addr),
        .q_id       (req_id),
        .d_addr     (st_q.da),
        .dup        (dup),
        .full       (full),
        .alloc_idx  (alloc_idx),
        .addr_hits  (addr_hits),
        .drain_hits (drain_hits)
    );

    cpa_first_set #(.W(DEPTH)) u_dpick (
        .vec   (drain_hits),
        .idx   (didx),
        .found (dfound)
    );

    always_comb begin
        op        = op_e'(req_type);
        slot_free = !st_q.rv || rsp_ready;
        hit       = st_q.bvld[req_addr];
        rest_hits = drain_hits;
        rest_hits[didx] = 1'b0;

        case (op)
            OP_READ: op_ok = hit ? slot_free : (dup || !full);
            default: op_ok = 1'b1;
        endcase
        req_ready = !st_q.drain && op_ok;
        fire      = req_valid && req_ready;

        st_d = st_q;

        if (st_q.rv && rsp_ready) begin
            st_d.rv = 1'b0;
        end

        // one delivery per free response slot while draining
        if (st_q.drain && slot_free) begin
            if (dfound) begin
                st_d.rv       = 1'b1;
                st_d.rid      = st_q.ti[didx];
                st_d.ra       = st_q.da;
                st_d.rd       = st_q.mem[st_q.da];
                st_d.tv[didx] = 1'b0;
            end
            if (!(|rest_hits)) begin
                st_d.drain = 1'b0;
            end
        end

        if (fire) begin
            case (op)
                OP_READ: begin
                    if (hit) begin
                        st_d.rv  = 1'b1;
                        st_d.rid = req_id;
                        st_d.ra  = req_addr;
                        st_d.rd  = st_q.mem[req_addr];
                    end else if (!dup) begin
                        st_d.tv[alloc_idx] = 1'b1;
                        st_d.ta[alloc_idx] = req_addr;
                        st_d.ti[alloc_idx] = req_id;
                    end
                end
                OP_OWN: begin
                    st_d.bvld[req_addr] = 1'b0;
                end
                OP_WB: begin
                    st_d.mem[req_addr]  = req_data;
                    st_d.bvld[req_addr] = 1'b1;
                    st_d.drain          = |addr_hits;
                    st_d.da             = req_addr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.bvld <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rv;
    assign rsp_id    = st_q.rid;
    assign rsp_addr  = st_q.ra;
    assign rsp_data  = st_q.rd;
endmodule

// File: rtl/cpa_checker.sv
module cpa_checker #(
    parameter int ADDR_W = 4,
    parameter int ID_W   = 3,
    parameter int DATA_W = 32,
    parameter int NBLK   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_type,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ID_W-1:0]   req_id,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ID_W-1:0]   rsp_id,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [DATA_W-1:0] rsp_data,
    input logic              drain,
    input logic [NBLK-1:0]   bvld
);
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id)
                                     && $stable(rsp_addr) && $stable(rsp_data));

    a_r8_closed_in_drain: assert property (@(posedge clk) disable iff (rst)
        drain |-> !req_ready);

    a_r5_drain_progress: assert property (@(posedge clk) disable iff (rst)
        drain && (!rsp_valid || rsp_ready) |=> rsp_valid);

    a_r2_hit_reply: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_type == 2'd0 && bvld[req_addr]
        |=> rsp_valid && rsp_addr == $past(req_addr) && rsp_id == $past(req_id));

    a_r3_owned_silent: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_type == 2'd0 && !bvld[req_addr] && !rsp_valid
        |=> !rsp_valid);

    a_r4_wb_sets_valid: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_type == 2'd2 |=> bvld[$past(req_addr)]);
endmodule

bind consumer_park_agent cpa_checker #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .DATA_W (DATA_W),
    .NBLK   (NBLK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_type  (req_type),
    .req_addr  (req_addr),
    .req_id    (req_id),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_id    (rsp_id),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data),
    .drain     (st_q.drain),
    .bvld      (st_q.bvld)
);

// File: tb/consumer_park_agent_tb.sv
`timescale 1ns/1ps
module consumer_park_agent_tb;
    localparam int AW = 4, IW = 3, DW = 32, DEP = 8, NB = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, rsp_ready = 1'b1;
    logic [1:0] req_type = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [IW-1:0] req_id = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, rsp_valid;
    logic [IW-1:0] rsp_id;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] rsp_data;

    always #4 clk = ~clk;

    consumer_park_agent #(.ADDR_W(AW), .ID_W(IW), .DATA_W(DW), .DEPTH(DEP)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_addr(req_addr), .req_id(req_id), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string cur = "R1";

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference
    bit            m_bv[NB];
    logic [DW-1:0] m_mem[NB];
    bit            m_tv[DEP];
    int            m_ta[DEP], m_ti[DEP];
    bit            m_rv, m_drain;
    int            m_rid, m_ra, m_da;
    logic [DW-1:0] m_rd;

    function automatic bit m_ready();
        bit dupf, fullf;
        if (m_drain) return 0;
        if (req_type != 2'd0) return 1;
        if (m_bv[req_addr]) return (!m_rv || rsp_ready);
        dupf = 0; fullf = 1;
        foreach (m_tv[i]) begin
            if (m_tv[i] && m_ta[i] == int'(req_addr) && m_ti[i] == int'(req_id)) dupf = 1;
            if (!m_tv[i]) fullf = 0;
        end
        return dupf || !fullf;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_bv[i]) begin m_bv[i] = 1; m_mem[i] = '0; end
            foreach (m_tv[i]) m_tv[i] = 0;
            m_rv = 0; m_drain = 0;
        end else begin
            automatic bit fire = req_valid && m_ready();
            automatic bit slot = !m_rv || rsp_ready;
            if (m_rv && rsp_ready) m_rv = 0;
            if (m_drain && slot) begin
                automatic bit got = 0;
                automatic bit more = 0;
                for (int i = 0; i < DEP; i++) begin
                    if (m_tv[i] && m_ta[i] == m_da) begin
                        if (!got) begin
                            got = 1; m_rv = 1; m_rid = m_ti[i]; m_ra = m_da;
                            m_rd = m_mem[m_da]; m_tv[i] = 0;
                        end else more = 1;
                    end
                end
                if (!more) m_drain = 0;
            end
            if (fire) begin
                case (req_type)
                    2'd0: if (m_bv[req_addr]) begin
                        m_rv = 1; m_rid = req_id; m_ra = req_addr; m_rd = m_mem[req_addr];
                    end else begin
                        automatic bit dupf = 0;
                        foreach (m_tv[i])
                            if (m_tv[i] && m_ta[i] == int'(req_addr) && m_ti[i] == int'(req_id)) dupf = 1;
                        if (!dupf) begin
                            for (int i = 0; i < DEP; i++) if (!m_tv[i]) begin
                                m_tv[i] = 1; m_ta[i] = req_addr; m_ti[i] = req_id; break;
                            end
                        end
                    end
                    2'd1: m_bv[req_addr] = 0;
                    2'd2: begin
                        m_mem[req_addr] = req_data; m_bv[req_addr] = 1;
                        m_drain = 0;
                        foreach (m_tv[i]) if (m_tv[i] && m_ta[i] == int'(req_addr)) m_drain = 1;
                        m_da = req_addr;
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison and delivery log
    int log_id[$], log_ad[$];
    logic [DW-1:0] log_dt[$];

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(req_ready == m_ready(), cur, "req_ready vs model", req_ready, m_ready());
            chk(rsp_valid == m_rv && (!m_rv || (int'(rsp_id) == m_rid && int'(rsp_addr) == m_ra
                && rsp_data == m_rd)), cur, "response vs model",
                {rsp_valid, rsp_id, rsp_addr}, {m_rv, IW'(m_rid), AW'(m_ra)});
            if (rsp_valid && rsp_ready) begin
                log_id.push_back(rsp_id); log_ad.push_back(rsp_addr); log_dt.push_back(rsp_data);
            end
        end
    end

    task automatic send(int op, int ad, int id, logic [DW-1:0] dt);
        bit r;
        req_valid = 1; req_type = 2'(op); req_addr = AW'(ad); req_id = IW'(id); req_data = dt;
        do begin
            @(negedge clk); r = req_ready;
            @(posedge clk);
        end while (!r);
        #1 req_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        log_id.delete(); log_ad.delete(); log_dt.delete();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
        chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
        @(posedge clk); #1;

        cur = "R2";
        clear_log();
        send(0, 5, 2, '0);
        idle(2);
        chk(log_id.size() == 1 && log_id[0] == 2 && log_ad[0] == 5 && log_dt[0] == 0,
            "R2", "read of reset block", log_dt.size(), 1);

        cur = "R4";
        clear_log();
        send(2, 3, 0, 32'hA5A5_0003);
        send(0, 3, 1, '0);
        idle(2);
        chk(log_id.size() == 1 && log_id[0] == 1 && log_dt[0] == 32'hA5A5_0003,
            "R4", "read after writeback data", log_dt.size() ? log_dt[0] : 0, 32'hA5A5_0003);

        cur = "R3";
        clear_log();
        send(1, 7, 0, '0);
        send(0, 7, 4, '0);
        idle(3);
        chk(log_id.size() == 0, "R3", "owned block read answered", log_id.size(), 0);
        cur = "R6";
        send(0, 7, 4, '0);
        send(0, 7, 1, '0);
        cur = "R10";
        send(1, 9, 0, '0);
        send(0, 9, 5, '0);
        idle(2);
        chk(log_id.size() == 0, "R10", "parked reads silent", log_id.size(), 0);
        cur = "R5";
        send(2, 7, 0, 32'hBEEF_0007);
        idle(5);
        chk(log_id.size() == 2, "R6", "duplicate gave one delivery", log_id.size(), 2);
        chk(log_id.size() == 2 && log_id[0] == 4 && log_id[1] == 1, "R5", "slot order of delivery",
            log_id.size() ? log_id[0] : 0, 4);
        chk(log_id.size() == 2 && log_dt[1] == 32'hBEEF_0007 && log_ad[1] == 7, "R5",
            "delivered data", log_id.size() > 1 ? log_dt[1] : 0, 32'hBEEF_0007);
        clear_log();
        cur = "R10";
        send(2, 9, 0, 32'h0000_0909);
        idle(3);
        chk(log_id.size() == 1 && log_id[0] == 5 && log_ad[0] == 9, "R10",
            "other block delivered on its writeback", log_id.size(), 1);

        // R7: fill the table
        cur = "R7";
        send(1, 2, 0, '0);
        for (int i = 0; i < DEP; i++) send(0, 2, i, '0);
        req_valid = 1; req_type = 2'd0; req_addr = 4'd2; req_id = 3'd0;
        @(negedge clk);
        chk(req_ready == 1, "R7", "duplicate read when full", req_ready, 1);
        @(posedge clk); #1 req_valid = 0;
        send(1, 6, 0, '0);
        req_valid = 1; req_type = 2'd0; req_addr = 4'd6; req_id = 3'd3;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(req_ready == 0, "R7", "new read when full", req_ready, 0);
        end
        @(posedge clk); #1 req_valid = 0;

        // R5/R8: drain eight with stalls
        cur = "R5";
        clear_log();
        send(2, 2, 0, 32'h2222_0002);
        fork
            begin
                for (int i = 0; i < 30; i++) begin
                    rsp_ready = (i % 3 != 2);
                    @(posedge clk); #1;
                end
                rsp_ready = 1;
            end
            begin
                req_valid = 1; req_type = 2'd1; req_addr = 4'd0; req_id = 3'd0;
                @(negedge clk);
                chk(req_ready == 0, "R8", "request during drain", req_ready, 0);
                @(posedge clk); #1;
                cur = "R8";
                send(1, 0, 0, '0);
            end
        join
        idle(3);
        chk(log_id.size() == DEP, "R5", "delivery count", log_id.size(), DEP);
        for (int i = 0; i < DEP; i++)
            chk(log_id.size() == DEP && log_id[i] == i && log_dt[i] == 32'h2222_0002, "R5",
                "ascending slot delivery", log_id.size() == DEP ? log_id[i] : -1, i);
        cur = "R7";
        send(0, 6, 3, '0);

        // R9: stalled response
        cur = "R9";
        rsp_ready = 0;
        send(0, 1, 6, '0);
        req_valid = 1; req_type = 2'd0; req_addr = 4'd4; req_id = 3'd2;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(req_ready == 0, "R9", "read with response stalled", req_ready, 0);
            chk(rsp_valid == 1 && rsp_id == 3'd6 && rsp_addr == 4'd1, "R9", "held response",
                rsp_id, 6);
        end
        @(posedge clk); #1 req_valid = 0; rsp_ready = 1;
        idle(2);
        send(0, 4, 2, '0);
        idle(3);
        summary();
    end
endmodule